// File: doc/BRIEF.md
# IDE Host Controller Interrupt Status Slice

This block holds the interrupt state of a two-channel IDE host controller. Each channel has one interrupt flag, and that flag can be seen at two configuration-space addresses. A level input from each channel's drive logic sets and clears the flag. Software clears a flag by writing a one to either of its views. A per-channel block bit masks the flag from the single shared interrupt-request line.

The block also decodes part of a 16-byte bus-master I/O region that holds one 4-byte window per channel:

- Byte 1 of a window is a view of the mode byte. Writing it updates only the two block bits.
- Byte 3 of a window is the channel's timing byte.
- Bytes 0 and 2 of a window are passed to an external command/status port. The data that port returns comes back unchanged as the read data.

Configuration reads are combinational. The shared interrupt line is registered.

Top module: `ide_irq_regs`

## Requirements
- R1: Each channel's flag can be read at two configuration addresses, and the two views always agree. Channel 0 is bit 2 of 0x50 and bit 2 of 0x71. Channel 1 is bit 4 of 0x57 and bit 3 of 0x71.
- R2: A configuration write with a one in a flag bit position, at any of that flag's addresses, clears the flag in both views. All other bits of 0x50, 0x57 and 0x71 are read-only on the configuration path. In particular, a configuration write to 0x71 does not change the block bits.
- R3: The channel flag is updated on the clock edge, according to the channel input `chan_irq[i]`:
  - A rising edge on `chan_irq[i]` sets the flag.
  - A falling edge on `chan_irq[i]` clears the flag.
  - In any other cycle, a software clear removes the flag, even while the input stays high.
- R4: If a rising input edge and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R5: The block bits are 0x71 bit 4 (channel 0) and 0x71 bit 5 (channel 1). They reset to 0 and change only through a single-byte I/O write to window byte 1. That write copies data bits 5:4 and leaves the flags untouched.
- R6: `irq_out` is 1 exactly when, in the previous cycle, at least one channel had its flag set and its block bit clear.
- R7: I/O address decoding works as follows:
  - Bit 3 of the I/O address selects the channel, and bits 1:0 select the byte.
  - Byte 1 reads the mode byte 0x71.
  - Byte 3 reads and writes the channel's timing byte.
  - The timing bytes are configuration 0x73 (channel 0) and 0x7B (channel 1), and both are also writable through configuration space.
- R8: An I/O access with `io_size` other than 0 is treated as wide (`io_size` 0 means 1 byte, 1 means 2 bytes, 2 or 3 mean 4 bytes):
  - A wide read returns 0x0000FFFF for 2 bytes and 0xFFFFFFFF for 4 bytes.
  - A wide write changes nothing.
  - A wide access is never forwarded.
- R9: A single-byte I/O access to window byte 0 or byte 2 raises `fwd_valid`. The external port sees:
  - `fwd_chan` = the channel;
  - `fwd_sel` = 0 for byte 0 and 1 for byte 2;
  - `fwd_we` and `fwd_wdata` = the access's write enable and data.

  For such a read, `io_rdata` equals `fwd_rdata`, zero-extended.
- R10: After reset:
  - 0x51 reads 0x04, or 0x0C when `SECONDARY_EN` is set.
  - 0x09 reads 0x8F and 0x3D reads 0x01.
  - Flags, block bits, timing bytes and `irq_out` are 0.
  - Configuration addresses that are not decoded read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_irq | input | 2 | Per-channel interrupt level from the drive side |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| io_en | input | 1 | I/O window access strobe |
| io_we | input | 1 | I/O access is a write |
| io_addr | input | 4 | Offset inside the 16-byte region |
| io_size | input | 2 | Access width code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| io_wdata | input | 8 | I/O write byte |
| io_rdata | output | 32 | I/O read data |
| fwd_valid | output | 1 | Access forwarded to the command/status port |
| fwd_we | output | 1 | Forwarded access is a write |
| fwd_chan | output | 1 | Channel of the forwarded access |
| fwd_sel | output | 1 | 0 = command byte, 1 = status byte |
| fwd_wdata | output | 8 | Forwarded write byte |
| fwd_rdata | input | 8 | Read byte returned by the command/status port |
| irq_out | output | 1 | Shared interrupt-request level |

## Verification
The assertions check the following on every cycle:
- an input edge moves its flag on the next edge;
- `irq_out` tracks the masked flags with one cycle of lag;
- the block bits hold still unless a single-byte I/O write occurs;
- wide accesses are never forwarded.

The two-view agreement, the write-one-to-clear behaviour at each address, the same-cycle priority of a rising input over a software clear, the byte decoding of the windows and the reset constants can only be shown by the bench's scenarios. Each of those depends on an address value and a read-back through the port.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int N_CH   = 2;
  localparam int TIM_W  = 8;
  localparam int IO_DW  = 32;
  localparam int IO_AW  = 4;

  localparam logic [7:0] A_PROGIF = 8'h09;
  localparam logic [7:0] A_INTPIN = 8'h3D;
  localparam logic [7:0] A_FLAG0  = 8'h50;
  localparam logic [7:0] A_ENABLE = 8'h51;
  localparam logic [7:0] A_FLAG1  = 8'h57;
  localparam logic [7:0] A_MODE   = 8'h71;
  localparam logic [7:0] A_TIM0   = 8'h73;
  localparam logic [7:0] TIM_STEP = 8'h08;

  localparam logic [7:0] PROGIF_VAL = 8'h8F;
  localparam logic [7:0] INTPIN_VAL = 8'h01;

  // Byte offsets inside one 4-byte channel window
  localparam logic [1:0] WB_CMD  = 2'd0;
  localparam logic [1:0] WB_MODE = 2'd1;
  localparam logic [1:0] WB_STAT = 2'd2;
  localparam logic [1:0] WB_TIM  = 2'd3;

  // Per-channel software clear requested by a configuration write
  function automatic logic [N_CH-1:0] cfg_clear(input logic we, input logic [7:0] a,
                                                input logic [7:0] d);
    cfg_clear = '0;
    if (we) begin
      case (a)
        A_FLAG0: cfg_clear[0] = d[2];
        A_FLAG1: cfg_clear[1] = d[4];
        A_MODE:  cfg_clear    = d[3:2];
        default: cfg_clear    = '0;
      endcase
    end
  endfunction

  // Composed mode byte: block bits at 5:4, flags at 3:2
  function automatic logic [7:0] mode_byte(input logic [N_CH-1:0] flag,
                                           input logic [N_CH-1:0] blk);
    mode_byte = {2'b00, blk, flag, 2'b00};
  endfunction

  // Read value returned for a wide I/O access
  function automatic logic [IO_DW-1:0] ones_fill(input logic [1:0] size);
    ones_fill = (size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [7:0] tim_addr(input int ch);
    tim_addr = A_TIM0 + TIM_STEP * ch[7:0];
  endfunction
endpackage

// File: rtl/ide_chan_slice.sv
module ide_chan_slice
  import ide_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_in,
  input  logic             sw_clr,
  input  logic             tim_we,
  input  logic [TIM_W-1:0] tim_wdata,
  output logic             flag,
  output logic [TIM_W-1:0] tim,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic prev_q;

  assign rise_ev = irq_in & ~prev_q;
  assign fall_ev = ~irq_in & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag   <= 1'b0;
      tim    <= '0;
    end else begin
      prev_q <= irq_in;
      if (rise_ev)      flag <= 1'b1;   // hardware set wins over a same-cycle clear
      else if (fall_ev) flag <= 1'b0;
      else if (sw_clr)  flag <= 1'b0;
      if (tim_we) tim <= tim_wdata;
    end
  end
endmodule

// File: rtl/ide_io_decode.sv
module ide_io_decode
  import ide_irq_pkg::*;
(
  input  logic             io_en,
  input  logic             io_we,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  output logic             single,
  output logic             chan,
  output logic             hit_mode,
  output logic             hit_tim,
  output logic             hit_fwd,
  output logic             blk_wr,
  output logic             tim_wr
);
  localparam int CH_BIT  = IO_AW - 1;
  localparam int HI_BIT  = IO_AW - 2;

  logic       lower;
  logic [1:0] bsel;

  assign single   = (io_size == 2'd0);
  assign chan     = io_addr[CH_BIT];
  assign lower    = ~io_addr[HI_BIT];
  assign bsel     = io_addr[1:0];
  assign hit_mode = io_en & single & lower & (bsel == WB_MODE);
  assign hit_tim  = io_en & single & lower & (bsel == WB_TIM);
  assign hit_fwd  = io_en & single & lower & ((bsel == WB_CMD) | (bsel == WB_STAT));
  assign blk_wr   = hit_mode & io_we;
  assign tim_wr   = hit_tim & io_we;
endmodule

// File: rtl/ide_irq_regs.sv
module ide_irq_regs
  import ide_irq_pkg::*;
#(
  parameter bit SECONDARY_EN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       chan_irq,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic             io_en,
  input  logic             io_we,
  input  logic [3:0]       io_addr,
  input  logic [1:0]       io_size,
  input  logic [7:0]       io_wdata,
  output logic [31:0]      io_rdata,
  output logic             fwd_valid,
  output logic             fwd_we,
  output logic             fwd_chan,
  output logic             fwd_sel,
  output logic [7:0]       fwd_wdata,
  input  logic [7:0]       fwd_rdata,
  output logic             irq_out
);
  localparam logic [7:0] ENABLE_VAL = 8'h04 | (SECONDARY_EN ? 8'h08 : 8'h00);

  logic [N_CH-1:0] flag, blk_q, sw_clr, rise_ev, fall_ev, tim_we;
  logic [TIM_W-1:0] tim [N_CH];
  logic [TIM_W-1:0] tim_wdata [N_CH];
  logic single, chan, hit_mode, hit_tim, hit_fwd, blk_wr, tim_wr;
  logic irq_q;
  logic [7:0] io_byte;

  ide_io_decode u_dec (
    .io_en(io_en), .io_we(io_we), .io_addr(io_addr), .io_size(io_size),
    .single(single), .chan(chan), .hit_mode(hit_mode), .hit_tim(hit_tim),
    .hit_fwd(hit_fwd), .blk_wr(blk_wr), .tim_wr(tim_wr)
  );

  assign sw_clr = cfg_clear(cfg_we, cfg_addr, cfg_wdata);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic io_tim_hit;
    logic cfg_tim_hit;
    assign io_tim_hit   = tim_wr & (chan == i[0]);
    assign cfg_tim_hit  = cfg_we & (cfg_addr == tim_addr(i));
    assign tim_we[i]    = io_tim_hit | cfg_tim_hit;
    assign tim_wdata[i] = io_tim_hit ? io_wdata : cfg_wdata;

    ide_chan_slice u_slice (
      .clk(clk), .rst_n(rst_n), .irq_in(chan_irq[i]), .sw_clr(sw_clr[i]),
      .tim_we(tim_we[i]), .tim_wdata(tim_wdata[i]), .flag(flag[i]),
      .tim(tim[i]), .rise_ev(rise_ev[i]), .fall_ev(fall_ev[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (blk_wr) blk_q <= io_wdata[5:4];
      irq_q <= |(flag & ~blk_q);
    end
  end
  assign irq_out = irq_q;

  always_comb begin
    case (cfg_addr)
      A_PROGIF: cfg_rdata = PROGIF_VAL;
      A_INTPIN: cfg_rdata = INTPIN_VAL;
      A_ENABLE: cfg_rdata = ENABLE_VAL;
      A_FLAG0:  cfg_rdata = {5'b0, flag[0], 2'b0};
      A_FLAG1:  cfg_rdata = {3'b0, flag[1], 4'b0};
      A_MODE:   cfg_rdata = mode_byte(flag, blk_q);
      default:  cfg_rdata = 8'h00;
    endcase
    if (cfg_addr == tim_addr(0)) cfg_rdata = tim[0];
    if (cfg_addr == tim_addr(1)) cfg_rdata = tim[1];
  end

  always_comb begin
    if (hit_fwd)       io_byte = fwd_rdata;
    else if (hit_mode) io_byte = mode_byte(flag, blk_q);
    else if (hit_tim)  io_byte = tim[chan];
    else               io_byte = 8'h00;
    io_rdata = single ? {24'h0, io_byte} : ones_fill(io_size);
  end

  assign fwd_valid = hit_fwd;
  assign fwd_we    = io_we;
  assign fwd_chan  = chan;
  assign fwd_sel   = io_addr[1];
  assign fwd_wdata = io_wdata;
endmodule

// File: rtl/ide_irq_regs_chk.sv
module ide_irq_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] chan_irq,
  input logic [1:0] flag,
  input logic [1:0] blk,
  input logic       irq_out,
  input logic       io_en,
  input logic       io_we,
  input logic [1:0] io_size,
  input logic       fwd_valid
);
  for (genvar i = 0; i < 2; i++) begin : g_a
    // R3: a rising input sets the flag on the next edge
    a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_irq[i]) |=> flag[i]);
    // R3: a falling input clears the flag on the next edge
    a_r3_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_irq[i]) |=> !flag[i]);
  end

  // R6: shared line follows the masked flags one cycle later
  a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(|(flag & ~blk))));

  // R5: block bits move only on an I/O write
  a_r5_blk_only_io: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_en && io_we) |=> $stable(blk));

  // R8: a wide write leaves the block bits alone
  a_r8_wide_no_blk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_en && io_we && io_size != 2'd0) |=> $stable(blk));

  // R8: a wide access is never forwarded
  a_r8_wide_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (io_en && io_size != 2'd0) |-> !fwd_valid);
endmodule

bind ide_irq_regs ide_irq_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chan_irq(chan_irq), .flag(flag), .blk(blk_q),
  .irq_out(irq_out), .io_en(io_en), .io_we(io_we), .io_size(io_size),
  .fwd_valid(fwd_valid)
);

// File: tb/tb_ide_irq_regs.sv
module tb_ide_irq_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] chan_irq = '0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0, cfg_wdata = '0;
  logic io_en = 1'b0, io_we = 1'b0;
  logic [3:0] io_addr = '0;
  logic [1:0] io_size = '0;
  logic [7:0] io_wdata = '0, fwd_rdata = '0;
  logic [7:0] cfg_rdata, fwd_wdata, cfg_rdata2, fwd_wdata2;
  logic [31:0] io_rdata, io_rdata2;
  logic fwd_valid, fwd_we, fwd_chan, fwd_sel, irq_out;
  logic fwd_valid2, fwd_we2, fwd_chan2, fwd_sel2, irq_out2;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  ide_irq_regs dut (
    .clk(clk), .rst_n(rst_n), .chan_irq(chan_irq), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_en(io_en), .io_we(io_we),
    .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .fwd_valid(fwd_valid), .fwd_we(fwd_we), .fwd_chan(fwd_chan), .fwd_sel(fwd_sel),
    .fwd_wdata(fwd_wdata), .fwd_rdata(fwd_rdata), .irq_out(irq_out)
  );

  ide_irq_regs #(.SECONDARY_EN(1'b1)) dut_sec (
    .clk(clk), .rst_n(rst_n), .chan_irq(chan_irq), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata2), .io_en(io_en), .io_we(io_we),
    .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata2),
    .fwd_valid(fwd_valid2), .fwd_we(fwd_we2), .fwd_chan(fwd_chan2), .fwd_sel(fwd_sel2),
    .fwd_wdata(fwd_wdata2), .fwd_rdata(fwd_rdata), .irq_out(irq_out2)
  );

  localparam logic [2:0] CW = 3'd0, CR = 3'd1, IW = 3'd2, IR = 3'd3, PIN = 3'd4, IRQ = 3'd5;
  localparam int NV = 36;
  // {req(4), op(3), addr(8), data(8), expected(8)}
  localparam logic [30:0] VEC [NV] = '{
    {4'd10, CR,  8'h09, 8'h00, 8'h8F},  // R10 programming interface
    {4'd10, CR,  8'h3D, 8'h00, 8'h01},  // R10 interrupt pin
    {4'd10, CR,  8'h51, 8'h00, 8'h04},  // R10 channel enable
    {4'd10, CR,  8'h71, 8'h00, 8'h00},  // R10 mode byte
    {4'd3,  PIN, 8'h00, 8'h01, 8'h00},  // R3 raise channel 0
    {4'd1,  CR,  8'h50, 8'h00, 8'h04},  // R1 view A ch0
    {4'd1,  CR,  8'h71, 8'h00, 8'h04},  // R1 view B ch0
    {4'd6,  IRQ, 8'h00, 8'h00, 8'h01},  // R6
    {4'd2,  CW,  8'h50, 8'hFB, 8'h00},  // R2 zero in flag bit
    {4'd2,  CR,  8'h50, 8'h00, 8'h04},  // R2
    {4'd5,  IW,  8'h01, 8'h10, 8'h00},  // R5 block ch0
    {4'd5,  IR,  8'h01, 8'h00, 8'h14},  // R5
    {4'd6,  IRQ, 8'h00, 8'h00, 8'h00},  // R6 masked
    {4'd2,  CW,  8'h71, 8'hFF, 8'h00},  // R2 clear via 0x71
    {4'd2,  CR,  8'h50, 8'h00, 8'h00},  // R2 other view cleared
    {4'd5,  CR,  8'h71, 8'h00, 8'h10},  // R5 block survives cfg write
    {4'd3,  PIN, 8'h01, 8'h01, 8'h00},  // R3 raise channel 1
    {4'd1,  CR,  8'h57, 8'h00, 8'h10},  // R1 view A ch1
    {4'd1,  CR,  8'h71, 8'h00, 8'h18},  // R1 view B ch1
    {4'd6,  IRQ, 8'h00, 8'h00, 8'h01},  // R6
    {4'd2,  CW,  8'h57, 8'h10, 8'h00},  // R2 clear via 0x57
    {4'd7,  IR,  8'h09, 8'h00, 8'h10},  // R7 ch1 window mode view
    {4'd6,  IRQ, 8'h00, 8'h00, 8'h00},  // R6
    {4'd7,  IW,  8'h0B, 8'hA5, 8'h00},  // R7 ch1 timing via I/O
    {4'd7,  CR,  8'h7B, 8'h00, 8'hA5},  // R7
    {4'd7,  CR,  8'h73, 8'h00, 8'h00},  // R7 ch0 untouched
    {4'd7,  CW,  8'h73, 8'h3C, 8'h00},  // R7 ch0 timing via cfg
    {4'd7,  IR,  8'h03, 8'h00, 8'h3C},  // R7
    {4'd3,  PIN, 8'h01, 8'h00, 8'h00},  // R3 fall
    {4'd3,  PIN, 8'h01, 8'h01, 8'h00},  // R3 rise again
    {4'd3,  CR,  8'h71, 8'h00, 8'h18},  // R3
    {4'd3,  PIN, 8'h01, 8'h00, 8'h00},  // R3 fall clears
    {4'd3,  CR,  8'h57, 8'h00, 8'h00},  // R3
    {4'd3,  PIN, 8'h00, 8'h00, 8'h00},  // R3 ch0 low
    {4'd5,  IW,  8'h01, 8'h00, 8'h00},  // R5 unblock
    {4'd1,  CR,  8'h71, 8'h00, 8'h00}   // R1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic io_write(input logic [3:0] a, input logic [7:0] d, input logic [1:0] sz);
    @(negedge clk); io_en = 1'b1; io_we = 1'b1; io_addr = a; io_wdata = d; io_size = sz;
    @(negedge clk); io_en = 1'b0; io_we = 1'b0; io_size = 2'd0;
  endtask

  task automatic set_pin(input int ch, input logic v);
    @(negedge clk); chan_irq[ch] = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 irq reset", {31'b0, irq_out}, 32'h0);
    cfg_addr = 8'h51; #1;
    chk("R10 secondary enable", {24'b0, cfg_rdata2}, 32'h0C);
    cfg_addr = 8'h20; #1;
    chk("R10 undecoded", {24'b0, cfg_rdata}, 32'h00);

    for (int k = 0; k < NV; k++) begin
      automatic logic [3:0] rq = VEC[k][30:27];
      automatic logic [2:0] op = VEC[k][26:24];
      automatic logic [7:0] ad = VEC[k][23:16];
      automatic logic [7:0] dt = VEC[k][15:8];
      automatic logic [7:0] ex = VEC[k][7:0];
      automatic string tag = $sformatf("R%0d step %0d", rq, k);
      case (op)
        CW:  cfg_write(ad, dt);
        IW:  io_write(ad[3:0], dt, 2'd0);
        PIN: set_pin(int'(ad[0]), dt[0]);
        CR:  begin cfg_addr = ad; #1; chk(tag, {24'b0, cfg_rdata}, {24'b0, ex}); end
        IR:  begin io_en = 1'b1; io_addr = ad[3:0]; io_size = 2'd0; #1;
                   chk(tag, io_rdata, {24'b0, ex}); io_en = 1'b0; end
        IRQ: begin @(negedge clk); chk(tag, {31'b0, irq_out}, {31'b0, ex[0]}); end
        default: ;
      endcase
    end

    // R4: rising input and software clear in the same cycle
    @(negedge clk); chan_irq[0] = 1'b1; cfg_we = 1'b1; cfg_addr = 8'h50; cfg_wdata = 8'h04;
    @(negedge clk); cfg_we = 1'b0; #1;
    chk("R4 set wins", {24'b0, cfg_rdata}, 32'h04);
    // R3: clear while input stays high
    cfg_write(8'h50, 8'h04); cfg_addr = 8'h71; #1;
    chk("R3 sw clear with input high", {24'b0, cfg_rdata}, 32'h00);

    // R8: wide reads and writes
    @(negedge clk); io_en = 1'b1; io_we = 1'b0; io_addr = 4'h1; io_size = 2'd1; #1;
    chk("R8 two-byte read", io_rdata, 32'h0000FFFF);
    io_size = 2'd2; #1;
    chk("R8 four-byte read", io_rdata, 32'hFFFFFFFF);
    io_addr = 4'h0; #1;
    chk("R8 wide not forwarded", {31'b0, fwd_valid}, 32'h0);
    io_en = 1'b0; io_size = 2'd0;
    io_write(4'h1, 8'h30, 2'd2);
    io_en = 1'b1; io_addr = 4'h1; #1;
    chk("R8 wide write ignored", io_rdata, 32'h00);
    io_en = 1'b0;
    io_write(4'hB, 8'h11, 2'd1);
    cfg_addr = 8'h7B; #1;
    chk("R8 wide timing write ignored", {24'b0, cfg_rdata}, 32'hA5);

    // R9: forwarding of bytes 0 and 2
    @(negedge clk); io_en = 1'b1; io_we = 1'b0; io_addr = 4'hA; fwd_rdata = 8'h5A; #1;
    chk("R9 read data", io_rdata, 32'h5A);
    chk("R9 valid/chan/sel", {29'b0, fwd_valid, fwd_chan, fwd_sel}, 32'h7);
    io_we = 1'b1; io_addr = 4'h0; io_wdata = 8'h77; #1;
    chk("R9 write fwd", {20'b0, fwd_valid, fwd_we, fwd_chan, fwd_sel, fwd_wdata},
        {20'b0, 4'b1100, 8'h77});
    io_addr = 4'h4; #1;
    chk("R9 upper half not forwarded", {31'b0, fwd_valid}, 32'h0);
    io_en = 1'b0; io_we = 1'b0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule